// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the bus-facing half of an SPI master. It decodes single-cycle reads and writes from an APB-style bus onto a small set of configuration, enable, slave-select, threshold and interrupt registers. It also holds a transmit FIFO and a receive FIFO that sit between the bus and a serial shift engine. The engine itself is outside the block. It reads configuration, slave-select enables and transmit words from this block, pushes received words back, and reports when it is busy.

Software programs the configuration while the controller is disabled and then sets the enable bit. After that it streams 16-bit words through a data window that covers several consecutive word addresses, so a bus burst can target any of them. Clearing the enable bit empties both FIFOs. FIFO levels, a read-only status word, raw and masked interrupt views and clear-on-read registers let software follow the traffic.

Top module: `spim_regfront`

Register byte offsets: 0x00 frame config, 0x04 receive-only frame count, 0x08 enable (bit 0), 0x0C slave-select enables, 0x10 baud divisor, 0x14 transmit threshold, 0x18 receive threshold, 0x1C transmit level, 0x20 receive level, 0x24 status, 0x28 interrupt mask, 0x2C masked interrupts, 0x30 raw interrupts, 0x34/0x38/0x3C clear transmit-overflow/receive-overflow/receive-underflow, 0x40 clear all three, 0x44 version, 0x60 to 0x7C data window (eight words by default).

## Requirements
- R1: Writes to 0x00, 0x04 and 0x10 take effect while the enable bit is 0. They are ignored while it is 1, and the old value reads back.
- R2: A data-window write while enabled pushes pwdata[15:0] into the transmit FIFO. While disabled the write is dropped and the transmit level stays 0.
- R3: While the enable bit is 0, both FIFO levels are 0. Clearing the bit empties both FIFOs.
- R4: Every word address in the data window behaves the same way. Writes push and reads pop, in FIFO order, and read bits 31:16 are 0.
- R5: A write to the slave-select register (0x0C) is ignored while eng_busy is 1.
- R6: The masked view (0x2C) equals raw AND mask. irq_o is the OR of the masked bits, and the mask resets to all ones.
- R7: Reads of 0x1C and 0x20 return the current transmit and receive entry counts.
- R8: Raw bit 0 (transmit-empty) is 1 when the transmit level is at or below the transmit threshold. Raw bit 4 (receive-full) is 1 when the receive level is above the receive threshold. Both thresholds reset to 0.
- R9: Reading 0x34, 0x38 or 0x3C clears raw bit 1, 3 or 2 respectively. Reading 0x40 clears all three.
- R10: A read of 0x44 returns 0x3130332A: the ASCII bytes "1", "0", "3", then "*".
- R11: A push to a full transmit FIFO discards the word and sets sticky raw bit 1. A data-window read of an empty receive FIFO returns 0 and sets sticky raw bit 2. An engine push to a full receive FIFO sets sticky raw bit 3.
- R12: The status word (0x24) is read-only, with bit 0 busy, bit 1 transmit not full, bit 2 transmit empty, bit 3 receive not empty and bit 4 receive full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | AW | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| eng_busy | input | 1 | Serial engine is shifting |
| tx_rd | input | 1 | Engine takes the transmit head |
| tx_valid | output | 1 | Transmit FIFO holds a word |
| tx_data | output | DW | Transmit FIFO head |
| rx_wr | input | 1 | Engine delivers a received word |
| rx_wdata | input | DW | Received word |
| enable_o | output | 1 | Enable bit |
| cfg0_o | output | 16 | Frame configuration |
| cfg1_o | output | 16 | Receive-only frame count |
| baud_o | output | 16 | Clock divisor |
| sel_en_o | output | NSS | Slave-select enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Read data is combinational and comes from registered state, so the bench samples prdata one time unit after it raises penable, well before the closing edge. A write or clear-on-read acts on the edge that ends its access phase, so the next bus transaction already sees the result. A flush lags the enable write by one more edge, and the bench reads the levels only after a full later transaction has begun. Engine pops are scored two time units after the falling edge that raises tx_rd. At that point tx_data still shows the head that the next rising edge removes.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int OFF_CFG0    = 'h00;
    localparam int OFF_CFG1    = 'h04;
    localparam int OFF_EN      = 'h08;
    localparam int OFF_SEL     = 'h0C;
    localparam int OFF_BAUD    = 'h10;
    localparam int OFF_TXTHR   = 'h14;
    localparam int OFF_RXTHR   = 'h18;
    localparam int OFF_TXLVL   = 'h1C;
    localparam int OFF_RXLVL   = 'h20;
    localparam int OFF_STAT    = 'h24;
    localparam int OFF_MASK    = 'h28;
    localparam int OFF_MSTAT   = 'h2C;
    localparam int OFF_RAW     = 'h30;
    localparam int OFF_CLR_TXO = 'h34;
    localparam int OFF_CLR_RXO = 'h38;
    localparam int OFF_CLR_RXU = 'h3C;
    localparam int OFF_CLR_ALL = 'h40;
    localparam int OFF_VER     = 'h44;
    localparam int OFF_DATA    = 'h60;

    localparam int IRQ_N   = 5;
    localparam int IRQ_TXE = 0;
    localparam int IRQ_TXO = 1;
    localparam int IRQ_RXU = 2;
    localparam int IRQ_RXO = 3;
    localparam int IRQ_RXF = 4;

    localparam logic [7:0]  VER_MAJOR = 8'h31;
    localparam logic [7:0]  VER_MID   = 8'h30;
    localparam logic [7:0]  VER_MINOR = 8'h33;
    localparam logic [31:0] VER_WORD  = {VER_MAJOR, VER_MID, VER_MINOR, 8'h2A};
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = bump(q.wp);
            if (do_pop)  d.rp = bump(q.rp);
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

    assign rdata = mem[q.rp];
    assign count = q.cnt;
endmodule

// File: rtl/spim_irq.sv
module spim_irq
    import spim_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    tx_lvl,
    input  logic [LW-1:0]    rx_lvl,
    input  logic [LW-1:0]    tx_thr,
    input  logic [LW-1:0]    rx_thr,
    input  logic [IRQ_N-1:0] mask,
    input  logic             set_txo,
    input  logic             set_rxo,
    input  logic             set_rxu,
    input  logic             clr_txo,
    input  logic             clr_rxo,
    input  logic             clr_rxu,
    output logic [IRQ_N-1:0] raw,
    output logic [IRQ_N-1:0] masked,
    output logic             irq
);
    typedef struct packed {
        logic txo;
        logic rxo;
        logic rxu;
    } sticky_t;

    sticky_t q, d;

    always_comb begin
        d     = q;
        d.txo = set_txo | (q.txo & ~clr_txo);
        d.rxo = set_rxo | (q.rxo & ~clr_rxo);
        d.rxu = set_rxu | (q.rxu & ~clr_rxu);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        raw          = '0;
        raw[IRQ_TXE] = (tx_lvl <= tx_thr);
        raw[IRQ_TXO] = q.txo;
        raw[IRQ_RXU] = q.rxu;
        raw[IRQ_RXO] = q.rxo;
        raw[IRQ_RXF] = (rx_lvl > rx_thr);
    end

    assign masked = raw & mask;
    assign irq    = |masked;
endmodule

// File: rtl/spim_regfront.sv
module spim_regfront
    import spim_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int DEPTH      = 8,
    parameter int NSS        = 4,
    parameter int DATA_WORDS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           psel,
    input  logic           penable,
    input  logic           pwrite,
    input  logic [AW-1:0]  paddr,
    input  logic [31:0]    pwdata,
    output logic [31:0]    prdata,
    input  logic           eng_busy,
    input  logic           tx_rd,
    output logic           tx_valid,
    output logic [DW-1:0]  tx_data,
    input  logic           rx_wr,
    input  logic [DW-1:0]  rx_wdata,
    output logic           enable_o,
    output logic [15:0]    cfg0_o,
    output logic [15:0]    cfg1_o,
    output logic [15:0]    baud_o,
    output logic [NSS-1:0] sel_en_o,
    output logic           irq_o
);
    localparam int LW      = $clog2(DEPTH + 1);
    localparam int WIN_END = OFF_DATA + 4 * DATA_WORDS;

    typedef struct packed {
        logic             en;
        logic [15:0]      cfg0;
        logic [15:0]      cfg1;
        logic [15:0]      baud;
        logic [NSS-1:0]   sel;
        logic [LW-1:0]    txthr;
        logic [LW-1:0]    rxthr;
        logic [IRQ_N-1:0] mask;
    } regs_t;

    regs_t q, d;

    logic          acc, wr, rd, in_win;
    int            a;
    logic          tx_push, tx_full, tx_empty;
    logic          rx_push, rx_pop, rx_full, rx_empty;
    logic [DW-1:0] rx_rdata;
    logic [LW-1:0] tx_cnt, rx_cnt;
    logic          clr_txo, clr_rxo, clr_rxu;
    logic [IRQ_N-1:0] irq_raw, irq_masked, irq_mask;

    assign acc    = psel && penable;
    assign wr     = acc && pwrite;
    assign rd     = acc && !pwrite;
    assign a      = int'(paddr);
    assign in_win = (a >= OFF_DATA) && (a < WIN_END);

    assign tx_push = wr && in_win && q.en;
    assign rx_pop  = rd && in_win;
    assign rx_push = rx_wr && q.en;

    assign clr_txo = rd && (a == OFF_CLR_TXO || a == OFF_CLR_ALL);
    assign clr_rxo = rd && (a == OFF_CLR_RXO || a == OFF_CLR_ALL);
    assign clr_rxu = rd && (a == OFF_CLR_RXU || a == OFF_CLR_ALL);

    spim_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(!q.en),
        .push(tx_push), .wdata(pwdata[DW-1:0]),
        .pop(tx_rd), .rdata(tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!q.en),
        .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_rdata),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_irq #(.LW(LW)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_lvl(tx_cnt), .rx_lvl(rx_cnt),
        .tx_thr(q.txthr), .rx_thr(q.rxthr), .mask(q.mask),
        .set_txo(tx_push && tx_full),
        .set_rxo(rx_push && rx_full),
        .set_rxu(rx_pop && rx_empty),
        .clr_txo(clr_txo), .clr_rxo(clr_rxo), .clr_rxu(clr_rxu),
        .raw(irq_raw), .masked(irq_masked), .irq(irq_o)
    );

    // Register next-state: configuration locks on enable, select locks on busy
    always_comb begin
        d = q;
        if (wr) begin
            case (a)
                OFF_CFG0:  if (!q.en) d.cfg0 = pwdata[15:0];
                OFF_CFG1:  if (!q.en) d.cfg1 = pwdata[15:0];
                OFF_BAUD:  if (!q.en) d.baud = pwdata[15:0];
                OFF_EN:    d.en = pwdata[0];
                OFF_SEL:   if (!eng_busy) d.sel = pwdata[NSS-1:0];
                OFF_TXTHR: d.txthr = pwdata[LW-1:0];
                OFF_RXTHR: d.rxthr = pwdata[LW-1:0];
                OFF_MASK:  d.mask = pwdata[IRQ_N-1:0];
                default:   d = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    // Read mux, valid during the access phase
    always_comb begin
        prdata = '0;
        if (in_win) begin
            prdata = rx_empty ? 32'd0 : 32'(rx_rdata);
        end else begin
            case (a)
                OFF_CFG0:    prdata = 32'(q.cfg0);
                OFF_CFG1:    prdata = 32'(q.cfg1);
                OFF_BAUD:    prdata = 32'(q.baud);
                OFF_EN:      prdata = 32'(q.en);
                OFF_SEL:     prdata = 32'(q.sel);
                OFF_TXTHR:   prdata = 32'(q.txthr);
                OFF_RXTHR:   prdata = 32'(q.rxthr);
                OFF_TXLVL:   prdata = 32'(tx_cnt);
                OFF_RXLVL:   prdata = 32'(rx_cnt);
                OFF_STAT:    prdata = 32'({rx_full, !rx_empty, tx_empty, !tx_full, eng_busy});
                OFF_MASK:    prdata = 32'(q.mask);
                OFF_MSTAT:   prdata = 32'(irq_masked);
                OFF_RAW:     prdata = 32'(irq_raw);
                OFF_CLR_TXO: prdata = 32'(irq_raw[IRQ_TXO]);
                OFF_CLR_RXO: prdata = 32'(irq_raw[IRQ_RXO]);
                OFF_CLR_RXU: prdata = 32'(irq_raw[IRQ_RXU]);
                OFF_CLR_ALL: prdata = 32'(irq_raw[IRQ_TXO] | irq_raw[IRQ_RXO] | irq_raw[IRQ_RXU]);
                OFF_VER:     prdata = VER_WORD;
                default:     prdata = '0;
            endcase
        end
    end

    assign irq_mask = q.mask;
    assign tx_valid = !tx_empty;
    assign enable_o = q.en;
    assign cfg0_o   = q.cfg0;
    assign cfg1_o   = q.cfg1;
    assign baud_o   = q.baud;
    assign sel_en_o = q.sel;
endmodule

// File: rtl/spim_regfront_chk.sv
module spim_regfront_chk
    import spim_pkg::*;
#(
    parameter int AW    = 8,
    parameter int NSS   = 4,
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [AW-1:0]    paddr,
    input logic             eng_busy,
    input logic             tx_rd,
    input logic             enable_o,
    input logic [15:0]      cfg0_o,
    input logic [NSS-1:0]   sel_en_o,
    input logic             irq_o,
    input logic [LW-1:0]    tx_cnt,
    input logic [LW-1:0]    rx_cnt,
    input logic [IRQ_N-1:0] raw,
    input logic [IRQ_N-1:0] mask
);
    logic acc_wr;
    assign acc_wr = psel && penable && pwrite;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && enable_o && int'(paddr) == OFF_CFG0 |=> $stable(cfg0_o)); // R1

    AST_TX_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && enable_o && int'(paddr) == OFF_DATA && !tx_rd && tx_cnt < LW'(DEPTH)
        |=> tx_cnt == $past(tx_cnt) + 1'b1); // R2

    AST_FLUSH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_o |=> tx_cnt == '0 && rx_cnt == '0); // R3

    AST_SEL_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && eng_busy && int'(paddr) == OFF_SEL |=> $stable(sel_en_o)); // R5

    AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & mask) == '0 |-> !irq_o); // R6

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= LW'(DEPTH) && rx_cnt <= LW'(DEPTH)); // R7
endmodule

bind spim_regfront spim_regfront_chk #(.AW(AW), .NSS(NSS), .DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .eng_busy(eng_busy), .tx_rd(tx_rd), .enable_o(enable_o),
    .cfg0_o(cfg0_o), .sel_en_o(sel_en_o), .irq_o(irq_o), .tx_cnt(tx_cnt),
    .rx_cnt(rx_cnt), .raw(irq_raw), .mask(irq_mask)
);

// File: tb/spim_regfront_test.sv
module spim_regfront_test;
    localparam int AW = 8, DW = 16, DEPTH = 8, NSS = 4, DATA_WORDS = 8;

    logic clk = 0, rst_n = 0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [AW-1:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic eng_busy = 0, tx_rd = 0, tx_valid, rx_wr = 0, enable_o, irq_o;
    logic [DW-1:0] tx_data, rx_wdata = '0;
    logic [15:0] cfg0_o, cfg1_o, baud_o;
    logic [NSS-1:0] sel_en_o;

    int checks = 0, fails = 0;
    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];
    logic [31:0] v;

    always #4 clk = ~clk;

    spim_regfront #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .NSS(NSS), .DATA_WORDS(DATA_WORDS)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .eng_busy(eng_busy),
        .tx_rd(tx_rd), .tx_valid(tx_valid), .tx_data(tx_data), .rx_wr(rx_wr),
        .rx_wdata(rx_wdata), .enable_o(enable_o), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o),
        .baud_o(baud_o), .sel_en_o(sel_en_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input int addr, input logic [31:0] data);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = AW'(addr); pwdata = data;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input int addr, output logic [31:0] data);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = AW'(addr);
        @(negedge clk); penable = 1; #1 data = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    // driver: data write, expected word goes to the scoreboard
    task automatic push_tx(input int addr, input logic [15:0] w, input bit expect_kept);
        apb_wr(addr, {16'hFFFF, w});
        if (expect_kept) txq.push_back(w);
    endtask

    task automatic eng_pop();
        @(negedge clk); tx_rd = 1;
        @(negedge clk); tx_rd = 0;
    endtask

    task automatic eng_push(input logic [15:0] w);
        @(negedge clk); rx_wr = 1; rx_wdata = w;
        @(negedge clk); rx_wr = 0;
    endtask

    // monitor: compares each word the stub engine takes (R4 order)
    always @(negedge clk) begin
        #2;
        if (tx_rd) begin
            if (txq.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 unexpected tx word actual=%h expected=none", tx_data);
            end else begin
                chk("R4 tx order", 32'(tx_data), 32'(txq.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state
        apb_rd('h24, v); chk("R12 status reset", v, 32'h6);
        apb_rd('h44, v); chk("R10 version", v, 32'h3130332A);
        apb_rd('h1C, v); chk("R7 tx level reset", v, 0);
        apb_rd('h30, v); chk("R8 raw reset", v, 32'h01);
        apb_rd('h28, v); chk("R6 mask reset", v, 32'h1F);
        chk("R6 irq reset", 32'(irq_o), 1);

        // R1 config writable while disabled
        apb_wr('h00, 32'h1234); apb_rd('h00, v); chk("R1 cfg0 write", v, 32'h1234);
        apb_wr('h10, 32'h0010); apb_rd('h10, v); chk("R1 baud write", v, 32'h10);

        // R2 data write dropped while disabled
        push_tx('h60, 16'hAAAA, 0);
        apb_rd('h1C, v); chk("R2 drop when disabled", v, 0);

        apb_wr('h08, 1);
        apb_wr('h00, 32'hBEEF); apb_rd('h00, v); chk("R1 cfg0 locked", v, 32'h1234);
        apb_wr('h10, 32'h0099); apb_rd('h10, v); chk("R1 baud locked", v, 32'h10);
        apb_wr('h04, 32'h0007); apb_rd('h04, v); chk("R1 cfg1 locked", v, 0);

        // R4 fill through every window address
        for (int i = 0; i < DATA_WORDS; i++) push_tx('h60 + 4 * i, 16'h0100 + 16'(i), 1);
        apb_rd('h1C, v); chk("R7 tx level full", v, 8);
        apb_rd('h24, v); chk("R12 status tx full", v, 32'h0);
        push_tx('h64, 16'hDEAD, 0);
        apb_rd('h30, v); chk("R11 tx overflow raw", v, 32'h02);
        for (int i = 0; i < DEPTH; i++) eng_pop();
        apb_rd('h1C, v); chk("R11 overflow word discarded", v, 0);
        chk("R4 scoreboard drained", txq.size(), 0);

        // R8 transmit threshold
        apb_wr('h14, 2);
        push_tx('h70, 16'h1111, 1); push_tx('h74, 16'h2222, 1); push_tx('h7C, 16'h3333, 1);
        apb_rd('h30, v); chk("R8 txe above thr", v & 1, 0);
        eng_pop();
        apb_rd('h30, v); chk("R8 txe at thr", v & 1, 1);
        eng_pop(); eng_pop();

        // R8 receive threshold, R4 mirrored reads
        apb_wr('h18, 1);
        eng_push(16'h5A5A); rxq.push_back(16'h5A5A);
        apb_rd('h30, v); chk("R8 rxf at thr", (v >> 4) & 1, 0);
        eng_push(16'hA5A5); rxq.push_back(16'hA5A5);
        apb_rd('h30, v); chk("R8 rxf above thr", (v >> 4) & 1, 1);
        apb_rd('h20, v); chk("R7 rx level", v, 2);
        apb_rd('h24, v); chk("R12 status rx data", v, 32'hE);
        apb_rd('h7C, v); chk("R4 read high mirror", v, 32'(rxq.pop_front()));
        apb_rd('h68, v); chk("R4 read mid mirror", v, 32'(rxq.pop_front()));

        // R11 underflow, R9 clears
        apb_rd('h60, v); chk("R11 empty read zero", v, 0);
        apb_rd('h30, v); chk("R11 rx underflow raw", (v >> 2) & 1, 1);
        apb_rd('h3C, v);
        apb_rd('h30, v); chk("R9 clear underflow", (v >> 2) & 1, 0);
        chk("R9 txo kept", (v >> 1) & 1, 1);
        apb_rd('h40, v);
        apb_rd('h30, v); chk("R9 clear all", v, 32'h01);

        // R6 masking
        apb_wr('h28, 32'h02);
        apb_rd('h2C, v); chk("R6 masked off", v, 0);
        chk("R6 irq low", 32'(irq_o), 0);
        apb_wr('h28, 32'h01);
        apb_rd('h2C, v); chk("R6 masked on", v, 1);
        chk("R6 irq high", 32'(irq_o), 1);
        apb_wr('h28, 0);
        chk("R6 irq off", 32'(irq_o), 0);

        // R5 slave select under busy
        apb_wr('h0C, 32'h3);
        chk("R5 sel idle write", 32'(sel_en_o), 3);
        eng_busy = 1;
        apb_wr('h0C, 32'hC);
        chk("R5 sel busy ignored", 32'(sel_en_o), 3);
        apb_rd('h24, v); chk("R12 status busy", v & 1, 1);
        eng_busy = 0;

        // R11 receive overflow, R9 clear
        for (int i = 0; i < DEPTH + 1; i++) eng_push(16'h0F00 + 16'(i));
        apb_rd('h30, v); chk("R11 rx overflow raw", (v >> 3) & 1, 1);
        apb_rd('h24, v); chk("R12 status rx full", (v >> 4) & 1, 1);
        apb_rd('h38, v);
        apb_rd('h30, v); chk("R9 clear rx overflow", (v >> 3) & 1, 0);

        // R3 disable flush
        push_tx('h60, 16'h7777, 0); push_tx('h60, 16'h8888, 0);
        apb_wr('h08, 0);
        apb_rd('h1C, v); chk("R3 tx flushed", v, 0);
        apb_rd('h20, v); chk("R3 rx flushed", v, 0);
        apb_wr('h00, 32'h4321); apb_rd('h00, v); chk("R1 cfg0 writable again", v, 32'h4321);
        txq.delete(); rxq.delete();

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule